// File: doc/BRIEF.md
# Block Memory Transfer Sequencer

This block carries out one block-copy instruction at a time. A decoder ahead of it hands over the opcode together with a 16-bit source address, a 16-bit destination address and a 16-bit byte count. The opcode selects how each of the two addresses moves after every byte.

The block first saves the three working registers (accumulator, X and Y) through a stack-write port. It then moves the bytes one at a time. Each byte takes one read and, later, one write on a single synchronous memory port.

While the copy runs, `busy` is high so that the core holding the block can hold back interrupts. The cost of the whole instruction is reported as a cycle total as soon as the instruction is accepted. A one-cycle `done` pulse marks the end of the copy.

There are two alternate-address modes. In these, one side toggles between a base address and base+1 on each byte, which suits a device that exposes its data through a two-byte port.

Top module: `bxfer_engine`

## Requirements
- R1: An instruction is accepted only when `instValid` is high while idle and `instOpcode` is one of 0x73, 0xC3, 0xD3, 0xE3 or 0xF3. Any other opcode leaves the block idle: `busy`, `memRd`, `memWr` and `stkWr` all stay low.
- R2: In the three cycles that follow acceptance, `stkWr` is high and `stkData` carries the accumulator, X and Y, in that order. These are the values presented on `regA`, `regX` and `regY` in the accepting cycle.
- R3: Byte b (counting from 0) is read at cycle 17+6b after acceptance, with `memRd` high and `memAddr` set to the source address. It is written at cycle 22+6b, with `memWr` high, `memAddr` set to the destination address, and `memWdata` equal to the data returned one cycle after the read.
- R4: Opcode 0x73 raises both the source and the destination address by one per byte.
- R5: Opcode 0xC3 lowers both the source and the destination address by one per byte.
- R6: Opcode 0xD3 raises the source address by one per byte and keeps the destination address at its base.
- R7: Opcode 0xE3 raises the source address while the destination address alternates between base and base+1. Opcode 0xF3 alternates the source address the same way while the destination address rises. In both cases the alternation begins at the base address on byte 0.
- R8: A byte count of zero moves 65536 bytes.
- R9: Address arithmetic wraps modulo 65536.
- R10: `busy` is high for exactly 17+6n cycles, where n is the effective byte count. `done` is high for exactly one cycle, the cycle after the last write, and `busy` is low in that cycle.
- R11: From the cycle after acceptance, `totalCycles` reads 17+6n and stays constant until the next instruction is accepted. It is zero after reset.
- R12: An instruction presented while `busy` is high is ignored, and the copy in progress continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instValid | input | 1 | Decoded instruction present |
| instOpcode | input | 8 | Instruction opcode |
| instSrc | input | 16 | Source base address |
| instDst | input | 16 | Destination base address |
| instLen | input | 16 | Byte count (0 means 65536) |
| regA | input | 8 | Accumulator value to save |
| regX | input | 8 | X register value to save |
| regY | input | 8 | Y register value to save |
| busy | output | 1 | Copy in progress; masks interrupts |
| done | output | 1 | One-cycle end-of-copy pulse |
| totalCycles | output | 20 | Cycle cost of the accepted instruction |
| memAddr | output | 16 | Memory address |
| memRd | output | 1 | Memory read strobe |
| memWr | output | 1 | Memory write strobe |
| memWdata | output | 8 | Memory write data |
| memRdata | input | 8 | Memory read data, valid the cycle after `memRd` |
| stkWr | output | 1 | Stack write strobe |
| stkData | output | 8 | Stack write data |

## Verification
The hardest case to reach from the ports is the zero-length copy. Run to the end, it would need almost 400,000 cycles. The bench therefore checks the reported total straight after acceptance and checks the first few bytes, including their addresses and timing. It then applies reset in mid-copy and confirms that the block returns to idle. A second case that is hard to reach is a new instruction arriving mid-copy. To cover it, the bench presents a valid instruction with different fields during both the register save and the byte phase, and confirms that every later strobe still follows the original instruction.

// File: rtl/bxfer_pkg.sv
package bxfer_pkg;

  localparam logic [7:0] OP_UP_UP     = 8'h73;
  localparam logic [7:0] OP_DN_DN     = 8'hC3;
  localparam logic [7:0] OP_UP_HOLD   = 8'hD3;
  localparam logic [7:0] OP_UP_ALT    = 8'hE3;
  localparam logic [7:0] OP_ALT_UP    = 8'hF3;

  localparam int PUSH_COUNT = 3;

  typedef enum logic [1:0] {
    STEP_INC  = 2'd0,
    STEP_DEC  = 2'd1,
    STEP_HOLD = 2'd2,
    STEP_ALT  = 2'd3
  } stepMode_t;

  typedef struct packed {
    logic      valid;
    stepMode_t srcMode;
    stepMode_t dstMode;
  } opDecode_t;

  typedef struct packed {
    logic       load;
    logic       pushEn;
    logic [1:0] pushSel;
    logic       rdEn;
    logic       capture;
    logic       wrEn;
    logic       advance;
  } dpStrobe_t;

  function automatic opDecode_t decodeOp(input logic [7:0] op);
    opDecode_t d;
    d = '{valid: 1'b0, srcMode: STEP_INC, dstMode: STEP_INC};
    case (op)
      OP_UP_UP:   d = '{valid: 1'b1, srcMode: STEP_INC, dstMode: STEP_INC};
      OP_DN_DN:   d = '{valid: 1'b1, srcMode: STEP_DEC, dstMode: STEP_DEC};
      OP_UP_HOLD: d = '{valid: 1'b1, srcMode: STEP_INC, dstMode: STEP_HOLD};
      OP_UP_ALT:  d = '{valid: 1'b1, srcMode: STEP_INC, dstMode: STEP_ALT};
      OP_ALT_UP:  d = '{valid: 1'b1, srcMode: STEP_ALT, dstMode: STEP_INC};
      default:    d = '{valid: 1'b0, srcMode: STEP_INC, dstMode: STEP_INC};
    endcase
    return d;
  endfunction

endpackage

// File: rtl/bxfer_addr_gen.sv
module bxfer_addr_gen
  import bxfer_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              load,
  input  logic              advance,
  input  stepMode_t         modeIn,
  input  logic [ADDR_W-1:0] baseIn,
  output logic [ADDR_W-1:0] addr
);

  stepMode_t         mode;
  logic [ADDR_W-1:0] ptr;
  logic              flip;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mode <= STEP_INC;
      ptr  <= '0;
      flip <= 1'b0;
    end else if (load) begin
      mode <= modeIn;
      ptr  <= baseIn;
      flip <= 1'b0;
    end else if (advance) begin
      case (mode)
        STEP_INC:  ptr  <= ptr + ADDR_W'(1);
        STEP_DEC:  ptr  <= ptr - ADDR_W'(1);
        STEP_HOLD: ptr  <= ptr;
        STEP_ALT:  flip <= ~flip;
        default:   ptr  <= ptr;
      endcase
    end
  end

  // flip only ever toggles in alternate mode, so the sum is exact elsewhere
  assign addr = ptr + ADDR_W'(flip);

endmodule

// File: rtl/bxfer_ctl.sv
module bxfer_ctl
  import bxfer_pkg::*;
#(
  parameter int PRO_CYC  = 17,
  parameter int STEP_CYC = 6
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       instValid,
  input  logic [7:0] instOpcode,
  input  logic       lastByte,
  output dpStrobe_t  strobe,
  output logic       busy,
  output logic       done
);

  localparam int CNT_W = $clog2(PRO_CYC);
  localparam int PH_W  = $clog2(STEP_CYC);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PRO_CYC - 1);
  localparam logic [PH_W-1:0]  PH_WRITE = PH_W'(STEP_CYC - 1);
  localparam logic [PH_W-1:0]  PH_GRAB  = PH_W'(1);

  typedef enum logic [1:0] {S_IDLE, S_SAVE, S_MOVE} ctlState_t;

  ctlState_t        state;
  logic [CNT_W-1:0] cnt;
  logic [PH_W-1:0]  phase;
  logic             doneQ;
  opDecode_t        dec;

  assign dec = decodeOp(instOpcode);

  always_comb begin
    strobe         = '0;
    strobe.load    = (state == S_IDLE) && instValid && dec.valid;
    strobe.pushEn  = (state == S_SAVE) && (cnt < CNT_W'(PUSH_COUNT));
    strobe.pushSel = cnt[1:0];
    strobe.rdEn    = (state == S_MOVE) && (phase == '0);
    strobe.capture = (state == S_MOVE) && (phase == PH_GRAB);
    strobe.wrEn    = (state == S_MOVE) && (phase == PH_WRITE);
    strobe.advance = strobe.wrEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      cnt   <= '0;
      phase <= '0;
      doneQ <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      case (state)
        S_IDLE: begin
          if (strobe.load) begin
            state <= S_SAVE;
            cnt   <= '0;
          end
        end
        S_SAVE: begin
          if (cnt == CNT_LAST) begin
            state <= S_MOVE;
            phase <= '0;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        S_MOVE: begin
          if (phase == PH_WRITE) begin
            phase <= '0;
            if (lastByte) begin
              state <= S_IDLE;
              doneQ <= 1'b1;
            end
          end else begin
            phase <= phase + PH_W'(1);
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy = (state != S_IDLE);
  assign done = doneQ;

endmodule

// File: rtl/bxfer_dp.sv
module bxfer_dp
  import bxfer_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int LEN_W    = 16,
  parameter int CYC_W    = 20,
  parameter int PRO_CYC  = 17,
  parameter int STEP_CYC = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [7:0]        instOpcode,
  input  logic [ADDR_W-1:0] instSrc,
  input  logic [ADDR_W-1:0] instDst,
  input  logic [LEN_W-1:0]  instLen,
  input  logic [DATA_W-1:0] regA,
  input  logic [DATA_W-1:0] regX,
  input  logic [DATA_W-1:0] regY,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic [DATA_W-1:0] stkData,
  output logic [CYC_W-1:0]  totalCycles,
  output logic              lastByte
);

  localparam int REM_W = LEN_W + 1;
  localparam logic [REM_W-1:0] FULL_LEN = REM_W'(1) << LEN_W;

  opDecode_t         dec;
  logic [REM_W-1:0]  effLen;
  logic [REM_W-1:0]  remaining;
  logic [DATA_W-1:0] saved [PUSH_COUNT];
  logic [DATA_W-1:0] dataHold;
  logic [CYC_W-1:0]  cycTotal;
  logic [ADDR_W-1:0] chanAddr [2];
  stepMode_t         chanMode [2];
  logic [ADDR_W-1:0] chanBase [2];

  assign dec      = decodeOp(instOpcode);
  assign effLen   = (instLen == '0) ? FULL_LEN : REM_W'(instLen);
  assign cycTotal = CYC_W'(PRO_CYC) + CYC_W'(STEP_CYC) * CYC_W'(effLen);

  assign chanMode[0] = dec.srcMode;
  assign chanMode[1] = dec.dstMode;
  assign chanBase[0] = instSrc;
  assign chanBase[1] = instDst;

  // channel 0 walks the source, channel 1 the destination
  for (genvar ch = 0; ch < 2; ch++) begin : g_chan
    bxfer_addr_gen #(.ADDR_W(ADDR_W)) u_gen (
      .clk    (clk),
      .rstN   (rstN),
      .load   (strobe.load),
      .advance(strobe.advance),
      .modeIn (chanMode[ch]),
      .baseIn (chanBase[ch]),
      .addr   (chanAddr[ch])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remaining   <= '0;
      dataHold    <= '0;
      totalCycles <= '0;
      for (int i = 0; i < PUSH_COUNT; i++) saved[i] <= '0;
    end else begin
      if (strobe.load) begin
        remaining   <= effLen;
        totalCycles <= cycTotal;
        saved[0]    <= regA;
        saved[1]    <= regX;
        saved[2]    <= regY;
      end else if (strobe.advance) begin
        remaining <= remaining - REM_W'(1);
      end
      if (strobe.capture) dataHold <= memRdata;
    end
  end

  assign lastByte = (remaining == REM_W'(1));
  assign memAddr  = strobe.wrEn ? chanAddr[1] : chanAddr[0];
  assign memWdata = dataHold;
  assign stkData  = (strobe.pushSel < 2'(PUSH_COUNT)) ? saved[strobe.pushSel] : '0;

endmodule

// File: rtl/bxfer_engine.sv
module bxfer_engine
  import bxfer_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int LEN_W    = 16,
  parameter int CYC_W    = 20,
  parameter int PRO_CYC  = 17,
  parameter int STEP_CYC = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instValid,
  input  logic [7:0]        instOpcode,
  input  logic [ADDR_W-1:0] instSrc,
  input  logic [ADDR_W-1:0] instDst,
  input  logic [LEN_W-1:0]  instLen,
  input  logic [DATA_W-1:0] regA,
  input  logic [DATA_W-1:0] regX,
  input  logic [DATA_W-1:0] regY,
  output logic              busy,
  output logic              done,
  output logic [CYC_W-1:0]  totalCycles,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRd,
  output logic              memWr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic              stkWr,
  output logic [DATA_W-1:0] stkData
);

  dpStrobe_t strobe;
  logic      lastByte;

  bxfer_ctl #(
    .PRO_CYC (PRO_CYC),
    .STEP_CYC(STEP_CYC)
  ) u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .instValid (instValid),
    .instOpcode(instOpcode),
    .lastByte  (lastByte),
    .strobe    (strobe),
    .busy      (busy),
    .done      (done)
  );

  bxfer_dp #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .LEN_W   (LEN_W),
    .CYC_W   (CYC_W),
    .PRO_CYC (PRO_CYC),
    .STEP_CYC(STEP_CYC)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .instOpcode (instOpcode),
    .instSrc    (instSrc),
    .instDst    (instDst),
    .instLen    (instLen),
    .regA       (regA),
    .regX       (regX),
    .regY       (regY),
    .memRdata   (memRdata),
    .memAddr    (memAddr),
    .memWdata   (memWdata),
    .stkData    (stkData),
    .totalCycles(totalCycles),
    .lastByte   (lastByte)
  );

  assign memRd = strobe.rdEn;
  assign memWr = strobe.wrEn;
  assign stkWr = strobe.pushEn;

endmodule

// File: rtl/bxfer_engine_chk.sv
module bxfer_engine_chk #(
  parameter int CYC_W    = 20,
  parameter int STEP_CYC = 6
) (
  input logic             clk,
  input logic             rstN,
  input logic             busy,
  input logic             done,
  input logic             memRd,
  input logic             memWr,
  input logic             stkWr,
  input logic [CYC_W-1:0] totalCycles
);

  localparam int GAP_W = $clog2(STEP_CYC + 1);

  logic [GAP_W-1:0] sinceRd;

  always_ff @(posedge clk) begin
    if (!rstN) sinceRd <= '0;
    else if (memRd) sinceRd <= GAP_W'(1);
    else if (sinceRd != '0 && sinceRd != GAP_W'(STEP_CYC)) sinceRd <= sinceRd + GAP_W'(1);
  end

  // R10: done lasts one cycle and never overlaps busy
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rstN) done |=> !done);
  a_r10_done_idle:   assert property (@(posedge clk) disable iff (!rstN) done |-> !busy);
  a_r10_fall_done:   assert property (@(posedge clk) disable iff (!rstN) $fell(busy) |-> done);

  // R3: the port is never read and written together, and only while busy
  a_r3_port_exclusive: assert property (@(posedge clk) disable iff (!rstN) !(memRd && memWr));
  a_r3_port_busy:      assert property (@(posedge clk) disable iff (!rstN) (memRd || memWr) |-> busy);
  a_r3_write_spacing:  assert property (@(posedge clk) disable iff (!rstN)
                                        memWr |-> (sinceRd == GAP_W'(STEP_CYC - 1)));

  // R2: stack writes only happen during a copy
  a_r2_stack_busy: assert property (@(posedge clk) disable iff (!rstN) stkWr |-> busy);

  // R11: reported total holds steady through a copy
  a_r11_total_steady: assert property (@(posedge clk) disable iff (!rstN)
                                       (busy && $past(busy)) |-> $stable(totalCycles));

endmodule

bind bxfer_engine bxfer_engine_chk #(.CYC_W(CYC_W), .STEP_CYC(STEP_CYC)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .busy       (busy),
  .done       (done),
  .memRd      (memRd),
  .memWr      (memWr),
  .stkWr      (stkWr),
  .totalCycles(totalCycles)
);

// File: tb/bxfer_engine_test.sv
`timescale 1ns/1ps
module bxfer_engine_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instValid = 1'b0;
  logic [7:0]  instOpcode = '0;
  logic [15:0] instSrc = '0, instDst = '0, instLen = '0;
  logic [7:0]  regA = '0, regX = '0, regY = '0;
  logic        busy, done, memRd, memWr, stkWr;
  logic [19:0] totalCycles;
  logic [15:0] memAddr;
  logic [7:0]  memWdata, stkData;
  logic [7:0]  memRdata = '0;

  int total = 0;
  int bad = 0;

  logic [7:0] mem [0:4095];

  always #4 clk = ~clk;

  bxfer_engine uut (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instOpcode(instOpcode),
    .instSrc(instSrc), .instDst(instDst), .instLen(instLen),
    .regA(regA), .regX(regX), .regY(regY),
    .busy(busy), .done(done), .totalCycles(totalCycles),
    .memAddr(memAddr), .memRd(memRd), .memWr(memWr), .memWdata(memWdata),
    .memRdata(memRdata), .stkWr(stkWr), .stkData(stkData)
  );

  always @(posedge clk) begin
    if (memRd) memRdata <= mem[memAddr[11:0]];
    if (memWr) mem[memAddr[11:0]] <= memWdata;
  end

  initial begin
    repeat (200000) @(posedge clk);
    $display("FAIL watchdog: run did not finish (act=hung exp=finished)");
    bad++;
    total++;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic check(input string tag, input bit ok, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // kinds: 0 up, 1 down, 2 hold, 3 alternate
  function automatic int srcKind(input logic [7:0] op);
    case (op)
      8'hC3: return 1;
      8'hF3: return 3;
      default: return 0;
    endcase
  endfunction

  function automatic int dstKind(input logic [7:0] op);
    case (op)
      8'hC3: return 1;
      8'hD3: return 2;
      8'hE3: return 3;
      default: return 0;
    endcase
  endfunction

  function automatic logic [15:0] expAddr(input int kind, input logic [15:0] base, input int b);
    case (kind)
      0: return base + 16'(b);
      1: return base - 16'(b);
      2: return base;
      default: return base + 16'(b % 2);
    endcase
  endfunction

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    instValid = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  // Runs one copy and checks every strobe each cycle; stopAt < 0 runs to completion,
  // pokeAt >= 0 presents a competing instruction at that cycle.
  task automatic runXfer(input string req, input logic [7:0] op, input logic [15:0] s,
                         input logic [15:0] d, input logic [15:0] l,
                         input int stopAt, input int pokeAt);
    int n = (l == 0) ? 65536 : int'(l);
    int full = 17 + 6 * n;
    int last = (stopAt >= 0 && stopAt < full) ? stopAt : full;
    int eCtl = 0, eStk = 0, eRd = 0, eWr = 0;
    longint aCtl = 0, xCtl = 0, aStk = 0, xStk = 0, aRd = 0, xRd = 0, aWr = 0, xWr = 0;
    logic [7:0] expData = '0;
    logic [7:0] pushVals [3];
    logic [7:0] a0 = op ^ l[7:0], x0 = s[7:0] + 8'h3C, y0 = d[7:0] ^ 8'hA5;
    pushVals[0] = a0; pushVals[1] = x0; pushVals[2] = y0;

    @(negedge clk);
    instOpcode = op; instSrc = s; instDst = d; instLen = l;
    regA = a0; regX = x0; regY = y0;
    instValid = 1'b1;
    @(negedge clk);
    instValid = 1'b0;
    regA = 8'h00; regX = 8'h00; regY = 8'h00;
    for (int c = 0; c <= last; c++) begin
      bit expBusy = (c < full);
      bit expDone = (c == full);
      bit expStk = (c < 3);
      bit expRd = 1'b0, expWr = 1'b0;
      int b = 0, p = 0;
      if (c >= 17 && c < full) begin
        b = (c - 17) / 6;
        p = (c - 17) % 6;
        expRd = (p == 0);
        expWr = (p == 5);
      end
      if (busy !== expBusy || done !== expDone) begin
        if (eCtl == 0) begin aCtl = {busy, done}; xCtl = {expBusy, expDone}; end
        eCtl++;
      end
      if (stkWr !== expStk || (expStk && stkData !== pushVals[c])) begin
        if (eStk == 0) begin aStk = {stkWr, stkData}; xStk = {expStk, expStk ? pushVals[c] : 8'h00}; end
        eStk++;
      end
      if (memRd !== expRd || (expRd && memAddr !== expAddr(srcKind(op), s, b))) begin
        if (eRd == 0) begin aRd = {memRd, memAddr}; xRd = {expRd, expAddr(srcKind(op), s, b)}; end
        eRd++;
      end
      if (expRd) expData = mem[expAddr(srcKind(op), s, b) & 16'h0FFF];
      if (memWr !== expWr || (expWr && (memAddr !== expAddr(dstKind(op), d, b) || memWdata !== expData))) begin
        if (eWr == 0) begin aWr = {memWr, memAddr, memWdata}; xWr = {expWr, expAddr(dstKind(op), d, b), expData}; end
        eWr++;
      end
      if (c == 0)
        check($sformatf("%s R11 total cycles at start", req), totalCycles === 20'(full), totalCycles, full);
      if (c == pokeAt) begin
        instOpcode = 8'hC3; instSrc = 16'h0E00; instDst = 16'h0F00; instLen = 16'd9;
        regA = 8'h5A; regX = 8'h5B; regY = 8'h5C;
        instValid = 1'b1;
      end else begin
        instValid = 1'b0;
      end
      @(negedge clk);
    end
    instValid = 1'b0;
    check($sformatf("%s R10 busy/done timing", req), eCtl == 0, aCtl, xCtl);
    check($sformatf("%s R2 stack save sequence", req), eStk == 0, aStk, xStk);
    check($sformatf("%s R3 read strobe/address", req), eRd == 0, aRd, xRd);
    check($sformatf("%s R3 write strobe/address/data", req), eWr == 0, aWr, xWr);
    if (last == full)
      check($sformatf("%s R10 done is one cycle", req), done === 1'b0 && busy === 1'b0, {busy, done}, 0);
  endtask

  task automatic testReset();
    doReset();
    @(negedge clk);
    check("R10 idle after reset", busy === 1'b0 && done === 1'b0, {busy, done}, 0);
    check("R11 total zero after reset", totalCycles === 20'd0, totalCycles, 0);
    check("R3 no strobes after reset", {memRd, memWr, stkWr} === 3'b000, {memRd, memWr, stkWr}, 0);
  endtask

  task automatic testBadOpcodes();
    logic [7:0] ops [3] = '{8'h74, 8'h00, 8'hB3};
    foreach (ops[i]) begin
      int hits = 0;
      @(negedge clk);
      instOpcode = ops[i]; instSrc = 16'h0100; instDst = 16'h0200; instLen = 16'd2;
      instValid = 1'b1;
      for (int c = 0; c < 24; c++) begin
        @(negedge clk);
        if (c == 2) instValid = 1'b0;
        if (busy !== 1'b0 || memRd !== 1'b0 || memWr !== 1'b0 || stkWr !== 1'b0) hits++;
      end
      check($sformatf("R1 opcode %02h ignored", ops[i]), hits == 0, hits, 0);
    end
  endtask

  task automatic testZeroLength();
    runXfer("R8 zero length", 8'h73, 16'h0C00, 16'h0D00, 16'h0000, 17 + 6 * 4, -1);
    doReset();
    @(negedge clk);
    check("R8 reset ends long copy", busy === 1'b0 && memRd === 1'b0, {busy, memRd}, 0);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 8'(i * 7 + 3) ^ 8'(i >> 4);
    testReset();
    testBadOpcodes();
    runXfer("R4 up/up", 8'h73, 16'h0100, 16'h0400, 16'd5, -1, -1);
    runXfer("R5 down/down", 8'hC3, 16'h0210, 16'h0610, 16'd4, -1, -1);
    runXfer("R6 up/hold", 8'hD3, 16'h0300, 16'h0800, 16'd3, -1, -1);
    runXfer("R7 up/alternate", 8'hE3, 16'h0320, 16'h0900, 16'd5, -1, -1);
    runXfer("R7 alternate/up", 8'hF3, 16'h0340, 16'h0A00, 16'd4, -1, -1);
    runXfer("R9 source wrap", 8'h73, 16'hFFFE, 16'h0B00, 16'd4, -1, -1);
    runXfer("R9 destination wrap", 8'hC3, 16'h0500, 16'h0001, 16'd4, -1, -1);
    runXfer("R10 single byte", 8'hD3, 16'h0580, 16'h0B80, 16'd1, -1, -1);
    runXfer("R12 start during save", 8'h73, 16'h0600, 16'h0C00, 16'd3, -1, 1);
    runXfer("R12 start during move", 8'hE3, 16'h0620, 16'h0C40, 16'd3, -1, 20);
    testZeroLength();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule